// File: doc/BRIEF.md
# SPI Slave Pause Controller

This block governs the pause feature of a serial-peripheral slave. It watches three asynchronous pins (the active-low select, the active-low pause pin and the serial clock) and resynchronises them on a fast system clock. From the synchronised levels it keeps a single pause state. While that state is set, a freeze flag stops the neighbouring command shifter and output logic, and a separate override forces the serial data pad to high impedance.

Entering and leaving the pause is qualified by the serial clock level. A change on the pause pin takes effect only while the serial clock is low. If the clock is high when the pin moves, the change waits for the next low phase. The shift counter and partial byte in the neighbouring logic stay untouched across a pause, so a transfer resumes at the bit where it stopped. If the host deselects the slave during a pause, the block emits a one-cycle reset pulse that tells the interface to drop the command in progress.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While the synchronised select pin is high (deselected), `freeze` is 0 whatever the pause pin and clock do.
- R2: With select low, the pause pin low and the serial clock low, `freeze` becomes 1.
- R3: If the pause pin falls while the serial clock is high, `freeze` stays 0 until the clock goes low, then becomes 1.
- R4: With `freeze` set, select low, the pause pin high and the serial clock low, `freeze` returns to 0.
- R5: If the pause pin rises while the serial clock is high, `freeze` stays 1 until the clock goes low. While the pause pin remains low, clock toggling leaves `freeze` at 1.
- R6: `so_hiz` equals `freeze` in every cycle.
- R7: A rising select pin while `freeze` is 1 gives exactly one system-clock cycle of `intf_rst` = 1 and clears `freeze`.
- R8: A rising select pin while `freeze` is 0 gives no `intf_rst` pulse.
- R9: During and straight after reset, `freeze`, `so_hiz` and `intf_rst` are 0.
- R10: With the default two synchroniser stages, a pin change set up before system-clock edge k shows on `freeze` after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for sampling and edge detection |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| cs_n_pin | input | 1 | Active-low select pin, asynchronous |
| hold_n_pin | input | 1 | Active-low pause pin, asynchronous |
| freeze | output | 1 | Pause active; stalls the shifter and output logic |
| so_hiz | output | 1 | Forces the serial data output to high impedance |
| intf_rst | output | 1 | One-cycle reset request to the interface logic |

## Verification
The bench moves the pause pin while the serial clock is high, in both directions. A design that acts on the pin at once would raise or drop `freeze` one clock phase early. It toggles the clock during a pause to make sure the state does not leave on clock activity alone. It also lowers the pause pin while the slave is deselected, where a design that skips the select check would freeze. The reset pulse is counted over several cycles, both for a deselect inside a pause and for one outside it. A level-based or missing pulse would show a wrong count. The synchroniser latency is measured edge by edge, so an added or missing stage shows up.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef struct packed {
    logic cs_n;
    logic hold_n;
    logic sck;
  } pin_set_t;

  localparam pin_set_t PINS_IDLE = '{cs_n: 1'b1, hold_n: 1'b1, sck: 1'b0};

  // Pause state for the next cycle: cleared when deselected, frozen while
  // the serial clock is high, and following the pause pin while it is low.
  function automatic logic hold_next(input logic held, input pin_set_t p);
    if (p.cs_n) return 1'b0;
    if (p.sck) return held;
    return !p.hold_n;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RESET_VAL;
        else        stage_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RESET_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[LAST];
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import spi_hold_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_set_t pins_s,
  output logic     held,
  output logic     intf_rst
);
  logic cs_prev;
  logic cs_rise;
  logic held_d;

  assign held_d  = hold_next(held, pins_s);
  assign cs_rise = pins_s.cs_n && !cs_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held     <= 1'b0;
      cs_prev  <= 1'b1;
      intf_rst <= 1'b0;
    end else begin
      held     <= held_d;
      cs_prev  <= pins_s.cs_n;
      intf_rst <= cs_rise && held;
    end
  end

  AST_NO_PAUSE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    pins_s.cs_n |=> !held); // R1
  AST_ENTER_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> $past(!pins_s.sck && !pins_s.hold_n && !pins_s.cs_n)); // R2
  AST_EXIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> $past(pins_s.cs_n || (!pins_s.sck && pins_s.hold_n))); // R4
  AST_STAY_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !pins_s.hold_n && !pins_s.cs_n) |=> held); // R5
  AST_RST_FROM_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    intf_rst |-> (!held && $past(held))); // R7
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    intf_rst |=> !intf_rst); // R7
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_pin,
  input  logic cs_n_pin,
  input  logic hold_n_pin,
  output logic freeze,
  output logic so_hiz,
  output logic intf_rst
);
  localparam int PIN_W = $bits(pin_set_t);

  pin_set_t pins_raw;
  pin_set_t pins_s;
  logic     held;

  assign pins_raw = '{cs_n: cs_n_pin, hold_n: hold_n_pin, sck: sck_pin};

  pin_sync #(
    .STAGES   (SYNC_STAGES),
    .WIDTH    (PIN_W),
    .RESET_VAL(PINS_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pins_raw),
    .dout (pins_s)
  );

  hold_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_s  (pins_s),
    .held    (held),
    .intf_rst(intf_rst)
  );

  assign freeze = held;
  assign so_hiz = held;

  AST_HIZ_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    so_hiz == freeze); // R6
  AST_RST_NEEDS_SELECT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    intf_rst |-> pins_s.cs_n); // R8
endmodule

// File: tb/spi_hold_ctrl_test.sv
module spi_hold_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck_pin = 1'b0;
  logic cs_n_pin = 1'b1;
  logic hold_n_pin = 1'b1;
  logic freeze, so_hiz, intf_rst;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  spi_hold_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sck_pin(sck_pin), .cs_n_pin(cs_n_pin),
    .hold_n_pin(hold_n_pin), .freeze(freeze), .so_hiz(so_hiz), .intf_rst(intf_rst)
  );

  // {cs_n, hold_n, sck, expected freeze}, each applied until settled
  localparam int NV = 12;
  localparam logic [3:0] VEC [NV] = '{
    4'b1_1_0_0, // idle
    4'b0_1_0_0, // selected
    4'b0_1_1_0, // clock high
    4'b0_0_1_0, // R3 pause pin low, clock high: deferred
    4'b0_0_0_1, // R3 clock low: pause begins
    4'b0_0_1_1, // R5 clock toggles while paused
    4'b0_1_1_1, // R5 pin released, clock high: still paused
    4'b0_1_0_0, // R4 clock low: pause ends
    4'b0_0_0_1, // R2 direct entry
    4'b0_1_0_0, // R4 direct exit
    4'b1_0_0_0, // R1 deselected with pause pin low
    4'b1_0_1_0  // R1 clock toggling while deselected
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drive(input logic cs, input logic h, input logic s);
    cs_n_pin = cs; hold_n_pin = h; sck_pin = s;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int pulses;
    @(negedge clk);
    check("R9 freeze in reset", freeze, 1'b0);
    check("R9 so_hiz in reset", so_hiz, 1'b0);
    check("R9 intf_rst in reset", intf_rst, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 freeze after reset", freeze, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][3], VEC[i][2], VEC[i][1]);
      repeat (4) @(negedge clk);
      check($sformatf("vector %0d freeze", i), freeze, VEC[i][0]);
      check($sformatf("R6 vector %0d so_hiz", i), so_hiz, VEC[i][0]);
    end

    // R10: latency, three edges from pin change to freeze
    drive(1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    drive(1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R10 not yet after two edges", freeze, 1'b0);
    @(negedge clk);
    check("R10 set after three edges", freeze, 1'b1);

    // R7: deselect during pause gives exactly one pulse
    repeat (2) @(negedge clk);
    pulses = 0;
    drive(1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (intf_rst) pulses++;
    end
    check("R7 one reset pulse", pulses == 1, 1'b1);
    check("R7 freeze cleared", freeze, 1'b0);

    // R8: deselect without pause gives no pulse
    drive(1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    pulses = 0;
    drive(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (intf_rst) pulses++;
    end
    check("R8 no reset pulse", pulses == 0, 1'b1);

    finish_run();
  end
endmodule